// File: doc/BRIEF.md
# Root Port Error and PME Signaling Control

This block holds the 16-bit root control register of a PCI Express root port. It turns error reports and power-management status into two requests for the rest of the chip. Configuration software writes the register through a byte-enabled write port and reads it back at any time. Only the low four bits hold state. Three of those bits choose which error severities (fatal, non-fatal uncorrectable, correctable) raise a system error request. The fourth bit allows a power-management event interrupt.

Error reports arrive as one-cycle pulses, one input per severity. A report may come from the port's own status logic or from a message decoded off the link. Any enabled severity produces a one-cycle system error request in the next cycle. The per-severity enables alone decide this, so the general SERR enable in the command register plays no part. The PME status level comes from the root status register. The interrupt pulses once when that status rises while the enable is set. It also pulses once when the enable is switched on while status is already pending.

Top module: `rp_err_pme_ctl`

## Requirements
- R1: After reset the register reads 0000h and both `serr_req` and `pme_irq` are low.
- R2: A write with `cfg_wr_be[0]` set loads bits 3:0 from `cfg_wr_data[3:0]` on the clock edge that samples the strobe. A write with `cfg_wr_be[0]` clear leaves those bits unchanged.
- R3: Bits 15:4 always read as zero, and a write to them, through either byte enable, has no effect.
- R4: With bit 2 set, a pulse on `ev_fatal` makes `serr_req` high for exactly the next cycle.
- R5: With bit 1 set, a pulse on `ev_nonfatal` makes `serr_req` high for exactly the next cycle.
- R6: With bit 0 set, a pulse on `ev_corr` makes `serr_req` high for exactly the next cycle.
- R7: An error whose enable bit is clear causes no request. Events in several enabled classes in the same cycle give one single-cycle request. The enables used are the register value before any write in that same cycle.
- R8: With bit 3 set, a rise of `pme_status` makes `pme_irq` high for exactly the next cycle.
- R9: When bit 3 goes from 0 to 1 while `pme_status` is high, `pme_irq` is high for exactly one cycle, in the cycle after the write takes effect.
- R10: While bit 3 stays set and `pme_status` stays high, no further `pme_irq` pulses occur. While bit 3 is clear, `pme_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wr_be | input | 2 | Byte enables of the write |
| cfg_wr_data | input | 16 | Write data |
| cfg_rd_data | output | 16 | Current register value |
| ev_fatal | input | 1 | Fatal error report pulse |
| ev_nonfatal | input | 1 | Non-fatal uncorrectable error report pulse |
| ev_corr | input | 1 | Correctable error report pulse |
| pme_status | input | 1 | PME status level from the root status register |
| serr_req | output | 1 | System error request pulse |
| pme_irq | output | 1 | PME interrupt request pulse |

## Verification
The hardest case to reach is the PME enable being switched on while status is already pending. The same edge can also coincide with a fresh status rise, and only one pulse may result. Random stimulus keeps `pme_status` high for long stretches and writes the register often. Directed sequences add a write that sets the enable under held status, a rise of status and a set of the enable in the same cycle, and long holds where any repeated pulse would show.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned CTL_BITS = 4;
  localparam int unsigned BE_W     = REG_W / 8;

  localparam int unsigned BIT_CORR  = 0;
  localparam int unsigned BIT_NFAT  = 1;
  localparam int unsigned BIT_FATAL = 2;
  localparam int unsigned BIT_PMEEN = 3;

  typedef struct packed {
    logic pme_en;
    logic fatal_en;
    logic nonfatal_en;
    logic corr_en;
  } ctl_t;
endpackage

// File: rtl/rpc_rst_sync.sv
module rpc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/rpc_cfg_reg.sv
module rpc_cfg_reg
  import rpc_pkg::*;
#(
  parameter int unsigned W    = REG_W,
  parameter int unsigned NCTL = CTL_BITS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   rdata,
  output logic [NCTL-1:0] ctl
);
  localparam int unsigned NB = W / 8;
  localparam logic [W-1:0] LIVE_MASK = W'((1 << NCTL) - 1);

  logic [W-1:0] be_mask;
  logic [W-1:0] wr_mask;
  logic [W-1:0] reg_q;
  logic [W-1:0] reg_d;
  logic         reg_en;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign be_mask[8*b +: 8] = {8{be[b]}};
  end

  always_comb begin
    wr_mask = be_mask & LIVE_MASK;
    reg_en  = wr & (|wr_mask);
    reg_d   = (reg_q & ~wr_mask) | (wdata & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (reg_en) reg_q <= reg_d;
  end

  assign rdata = reg_q & LIVE_MASK;
  assign ctl   = reg_q[NCTL-1:0];
endmodule

// File: rtl/rpc_serr_gen.sv
module rpc_serr_gen #(
  parameter int unsigned NCLS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] cls_en,
  input  logic [NCLS-1:0] cls_ev,
  output logic            serr
);
  logic serr_d;
  logic serr_q;

  always_comb begin
    serr_d = |(cls_en & cls_ev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_q <= 1'b0;
    else        serr_q <= serr_d;
  end

  assign serr = serr_q;
endmodule

// File: rtl/rpc_pme_gen.sv
module rpc_pme_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic status,
  output logic irq
);
  logic en_prev_q;
  logic st_prev_q;
  logic irq_q;
  logic irq_d;
  logic st_rise;
  logic en_rise;

  always_comb begin
    st_rise = status & ~st_prev_q;
    en_rise = en & ~en_prev_q;
    irq_d   = en & status & (st_rise | en_rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev_q <= 1'b0;
      st_prev_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      en_prev_q <= en;
      st_prev_q <= status;
      irq_q     <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/rp_err_pme_ctl.sv
module rp_err_pme_ctl
  import rpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [BE_W-1:0]  cfg_wr_be,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             ev_fatal,
  input  logic             ev_nonfatal,
  input  logic             ev_corr,
  input  logic             pme_status,
  output logic             serr_req,
  output logic             pme_irq
);
  logic                rst_n_sync;
  logic [CTL_BITS-1:0] ctl_bits;
  ctl_t                ctl;
  logic [2:0]          cls_en;
  logic [2:0]          cls_ev;

  rpc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  rpc_cfg_reg #(.W(REG_W), .NCTL(CTL_BITS)) u_reg (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .wr    (cfg_wr),
    .be    (cfg_wr_be),
    .wdata (cfg_wr_data),
    .rdata (cfg_rd_data),
    .ctl   (ctl_bits)
  );

  assign ctl    = ctl_t'(ctl_bits);
  assign cls_en = {ctl.fatal_en, ctl.nonfatal_en, ctl.corr_en};
  assign cls_ev = {ev_fatal, ev_nonfatal, ev_corr};

  rpc_serr_gen #(.NCLS(3)) u_serr (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .cls_en (cls_en),
    .cls_ev (cls_ev),
    .serr   (serr_req)
  );

  rpc_pme_gen u_pme (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .en     (ctl.pme_en),
    .status (pme_status),
    .irq    (pme_irq)
  );
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rd,
  input logic        ev_fatal,
  input logic        ev_nonfatal,
  input logic        ev_corr,
  input logic        pme_status,
  input logic        serr_req,
  input logic        pme_irq
);
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd[15:4] == 12'h000);
  a_r4_fatal_serr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fatal && rd[2] |=> serr_req);
  a_r5_nonfatal_serr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nonfatal && rd[1] |=> serr_req);
  a_r6_corr_serr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_corr && rd[0] |=> serr_req);
  a_r7_no_spurious_serr: assert property (@(posedge clk) disable iff (!rst_n)
    !((ev_fatal && rd[2]) || (ev_nonfatal && rd[1]) || (ev_corr && rd[0])) |=> !serr_req);
  a_r8_pme_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pme_status) && rd[3] |=> pme_irq);
  a_r10_pme_single: assert property (@(posedge clk) disable iff (!rst_n)
    pme_irq |=> !pme_irq);
  a_r10_pme_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !rd[3] |=> !pme_irq);
endmodule

bind rp_err_pme_ctl rpc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .rd          (cfg_rd_data),
  .ev_fatal    (ev_fatal),
  .ev_nonfatal (ev_nonfatal),
  .ev_corr     (ev_corr),
  .pme_status  (pme_status),
  .serr_req    (serr_req),
  .pme_irq     (pme_irq)
);

// File: tb/rp_err_pme_ctl_bench.sv
module rp_err_pme_ctl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_wr_be;
  logic [15:0] cfg_wr_data;
  logic [15:0] cfg_rd_data;
  logic        ev_fatal, ev_nonfatal, ev_corr, pme_status;
  logic        serr_req, pme_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [3:0] m_en;
  logic       m_en_prev, m_st_prev;

  rp_err_pme_ctl u_rp_err_pme_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wr_be(cfg_wr_be),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .ev_fatal(ev_fatal), .ev_nonfatal(ev_nonfatal), .ev_corr(ev_corr),
    .pme_status(pme_status), .serr_req(serr_req), .pme_irq(pme_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_serr(logic [3:0] en, logic f, logic n, logic c);
    return (f & en[2]) | (n & en[1]) | (c & en[0]);
  endfunction

  function automatic logic exp_irq(logic en, logic en_prev, logic st, logic st_prev);
    return en & st & (~st_prev | ~en_prev);
  endfunction

  function automatic logic [3:0] exp_reg(logic [3:0] cur, logic wr, logic [1:0] be,
                                         logic [15:0] d);
    return (wr && be[0]) ? d[3:0] : cur;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [1:0] be, logic [15:0] d,
                      logic f, logic n, logic c, logic st, string tag);
    logic es, ei;
    @(negedge clk);
    cfg_wr = wr; cfg_wr_be = be; cfg_wr_data = d;
    ev_fatal = f; ev_nonfatal = n; ev_corr = c; pme_status = st;
    es = exp_serr(m_en, f, n, c);
    ei = exp_irq(m_en[3], m_en_prev, st, m_st_prev);
    m_en_prev = m_en[3];
    m_st_prev = st;
    m_en = exp_reg(m_en, wr, be, d);
    @(posedge clk);
    #1;
    check({tag, " R4 R5 R6 R7 serr"}, {15'd0, serr_req}, {15'd0, es});
    check({tag, " R8 R9 R10 pme"}, {15'd0, pme_irq}, {15'd0, ei});
    check({tag, " R2 R3 reg"}, cfg_rd_data, {12'h000, m_en});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cfg_wr = 0; cfg_wr_be = 0; cfg_wr_data = 0;
    ev_fatal = 0; ev_nonfatal = 0; ev_corr = 0; pme_status = 0;
    m_en = 0; m_en_prev = 0; m_st_prev = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset rd", cfg_rd_data, 16'h0000);
    check("R1 reset serr", {15'd0, serr_req}, 16'd0);
    check("R1 reset pme", {15'd0, pme_irq}, 16'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3 reserved byte write and reserved low-byte bits
    step(1, 2'b10, 16'hFFFF, 0, 0, 0, 0, "R3 hi byte");
    step(1, 2'b11, 16'hFFF0, 0, 0, 0, 0, "R3 all res");
    // R7 disabled classes
    step(0, 0, 0, 1, 1, 1, 0, "R7 disabled");
    // R2 be[0] clear ignored
    step(1, 2'b00, 16'h000F, 0, 0, 0, 0, "R2 no be");
    // R4 R5 R6 one at a time
    step(1, 2'b01, 16'h0004, 0, 0, 0, 0, "R4 en");
    step(0, 0, 0, 1, 0, 0, 0, "R4 fatal");
    step(0, 0, 0, 0, 0, 0, 0, "R4 gap");
    step(1, 2'b01, 16'h0002, 0, 0, 0, 0, "R5 en");
    step(0, 0, 0, 0, 1, 0, 0, "R5 nonfatal");
    step(0, 0, 0, 1, 0, 0, 0, "R7 fatal off");
    step(1, 2'b01, 16'h0001, 0, 0, 0, 0, "R6 en");
    step(0, 0, 0, 0, 0, 1, 0, "R6 corr");
    // R7 simultaneous, and write in same cycle as event
    step(1, 2'b01, 16'h0007, 0, 0, 0, 0, "R7 all en");
    step(0, 0, 0, 1, 1, 1, 0, "R7 simul");
    step(1, 2'b01, 16'h0000, 1, 0, 0, 0, "R7 old en");
    step(0, 0, 0, 1, 0, 0, 0, "R7 now off");
    // R10 enable clear, status rises
    step(0, 0, 0, 0, 0, 0, 1, "R10 dis rise");
    // R9 enable set with status pending
    step(1, 2'b01, 16'h0008, 0, 0, 0, 1, "R9 set en");
    step(0, 0, 0, 0, 0, 0, 1, "R9 pulse");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 1, "R10 hold");
    // R8 status fall and rise
    step(0, 0, 0, 0, 0, 0, 0, "R8 fall");
    step(0, 0, 0, 0, 0, 0, 1, "R8 rise");
    // enable rise and status rise coinciding
    step(1, 2'b01, 16'h0000, 0, 0, 0, 0, "R9 clr");
    step(1, 2'b01, 16'h0008, 0, 0, 0, 0, "R9 set");
    step(0, 0, 0, 0, 0, 0, 1, "R8 rise en");
    step(1, 2'b01, 16'h0000, 0, 0, 0, 1, "R9 clr2");
    step(1, 2'b01, 16'h0008, 0, 0, 0, 0, "R9 set st0");
    step(1, 2'b01, 16'h0000, 0, 0, 0, 1, "R10 en drop");
    step(0, 0, 0, 0, 0, 0, 1, "R10 off");

    // random mix, status held in long stretches
    for (int i = 0; i < 4000; i++) begin
      logic        w;
      logic [1:0]  be;
      logic [15:0] d;
      logic        st;
      w  = ($urandom_range(0, 3) == 0);
      be = 2'($urandom);
      d  = 16'($urandom);
      st = ($urandom_range(0, 7) == 0) ? ~m_st_prev : m_st_prev;
      step(w, be, d, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 3) == 0), st, "rand");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule